// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block owns sixteen pads, each of which either serves a fixed bus-side signal or acts as a general-purpose I/O bit under software control. A per-pin select register picks the owner of each pad. For the pads handed to software, a direction register and a data register decide whether the pad drives and what level it drives. Pad levels are always brought in through a two-stage synchronizer before software reads them or they are forwarded to the DMA logic.

The bus-side signals are plain ports here. The upper address byte, the transfer-in-progress flag, the three transfer-mode bits and the two transfer-type bits are outputs toward the pads. The two DMA request lines come in from the pads. Software reaches the three registers through a flat address/write-enable/data interface. Writes take effect at the clock edge and reads are combinational.

Top module: `pmx_port_top`

## Requirements
- R1: After reset, the select register reads 0xFFFF, the direction register reads 0x0000, and the data register reads the synchronized pad levels, which are 0 right after reset. At reset every pad serves its bus-side function.
- R2: A pad whose select bit is 1 carries its bus signal. Pads 15..8 carry address bits 7..0 of `bus_addr_hi`, pad 7 carries `bus_tip`, pads 4..2 carry `bus_tmode[2:0]` and pads 1..0 carry `bus_ttype[1:0]`, each with `pad_oe` = 1.
- R3: A pad whose select bit is 0 and whose direction bit is 0 has `pad_oe` = 0.
- R4: A pad whose select bit is 0 always presents its data register bit on `pad_out`. `pad_oe` is 1 exactly when its direction bit is 1.
- R5: Reading the data register returns the stored bit for direction-1 bits and the pad level for direction-0 bits. The pad level appears in the read value two clock edges after it is applied. Writing the data register does not change what is read for direction-0 bits.
- R6: A data bit written while its pad is an input is kept. It is driven as soon as the direction bit becomes 1, with no further write needed.
- R7: Writing the direction or data register does not alter `pad_out` or `pad_oe` of any pad whose select bit is 1.
- R8: With select bits 6 and 5 set, pads 6 and 5 are inputs (`pad_oe` = 0). `dma_req[1]` and `dma_req[0]` follow those pads two edges later. A `dma_req` bit whose pad select bit is 0 stays 0.
- R9: The select register is at offset 0x004, the direction register at 0x244 and the data register at 0x248. Reads of any other offset return 0, and writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Register offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| pad_in | input | 16 | Level seen at each pad |
| pad_out | output | 16 | Level offered to each pad |
| pad_oe | output | 16 | Output enable for each pad |
| bus_addr_hi | input | 8 | Upper address byte from the bus controller |
| bus_tip | input | 1 | Transfer-in-progress flag |
| bus_tmode | input | 3 | Transfer-mode bits |
| bus_ttype | input | 2 | Transfer-type bits |
| dma_req | output | 2 | Synchronized DMA request lines |

## Verification
The hardest case to reach is a data bit written while its pad is an input and then made to drive. No single register write shows that the bit was kept. The stimulus first writes the data register with all pads as inputs, confirms that no pad drives, and only then raises the direction bits and compares `pad_out` with the earlier write. The two-edge synchronizer latency is pinned down by changing `pad_in` and reading the data register after one edge and again after two.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int PINS = 16;
  localparam int AW   = 12;

  localparam logic [AW-1:0] OFS_SEL = 12'h004;
  localparam logic [AW-1:0] OFS_DIR = 12'h244;
  localparam logic [AW-1:0] OFS_DAT = 12'h248;

  // pads whose bus function drives the pad (pads 6,5 are DMA inputs)
  localparam logic [PINS-1:0] BUS_DRIVES = 16'hFF9F;
  localparam logic [PINS-1:0] SEL_RESET  = '1;

  localparam int DREQ_LO = 5;

  function automatic logic [PINS-1:0] bus_pack(input logic [7:0] ahi,
                                               input logic tip,
                                               input logic [2:0] tm,
                                               input logic [1:0] tt);
    return {ahi, tip, 2'b00, tm, tt};
  endfunction

  function automatic logic [PINS-1:0] gpio_view(input logic [PINS-1:0] dir,
                                                input logic [PINS-1:0] dat,
                                                input logic [PINS-1:0] pins);
    return (dir & dat) | (~dir & pins);
  endfunction
endpackage

// File: rtl/pmx_sync.sv
module pmx_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1_q, stage2_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      warm_q   <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  assign dout = stage2_q;

  // R5
  sync_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/pmx_regs.sv
module pmx_regs
  import pmx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            we,
  input  logic [PINS-1:0] wdata,
  input  logic [PINS-1:0] pins_sync,
  output logic [PINS-1:0] rdata,
  output logic [PINS-1:0] sel_q,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] dat_q
);
  logic hit_sel, hit_dir, hit_dat, hit_any;

  assign hit_sel = (addr == OFS_SEL);
  assign hit_dir = (addr == OFS_DIR);
  assign hit_dat = (addr == OFS_DAT);
  assign hit_any = hit_sel | hit_dir | hit_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_RESET;
      dir_q <= '0;
      dat_q <= '0;
    end else if (we) begin
      if (hit_sel) sel_q <= wdata;
      if (hit_dir) dir_q <= wdata;
      if (hit_dat) dat_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_sel) rdata = sel_q;
    if (hit_dir) rdata = dir_q;
    if (hit_dat) rdata = gpio_view(dir_q, dat_q, pins_sync);
  end

  // R9
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |-> (rdata == '0));

  // R9
  undef_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hit_any) |=> ($stable(sel_q) && $stable(dir_q) && $stable(dat_q)));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && hit_dat) |=> $stable(dat_q));
endmodule

// File: rtl/pmx_pinmux.sv
module pmx_pinmux #(
  parameter int                W      = 16,
  parameter logic [W-1:0]      DRIVES = '1
) (
  input  logic [W-1:0] sel,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] dat,
  input  logic [W-1:0] bus_val,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (DRIVES[i]) begin : g_bus_out
      assign pad_out[i] = sel[i] ? bus_val[i] : dat[i];
      assign pad_oe[i]  = sel[i] | dir[i];
    end else begin : g_bus_in
      assign pad_out[i] = sel[i] ? 1'b0 : dat[i];
      assign pad_oe[i]  = ~sel[i] & dir[i];
    end
  end
endmodule

// File: rtl/pmx_port_top.sv
module pmx_port_top
  import pmx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_we,
  input  logic [PINS-1:0] reg_wdata,
  output logic [PINS-1:0] reg_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  input  logic [7:0]      bus_addr_hi,
  input  logic            bus_tip,
  input  logic [2:0]      bus_tmode,
  input  logic [1:0]      bus_ttype,
  output logic [1:0]      dma_req
);
  logic [PINS-1:0] pins_sync, sel_q, dir_q, dat_q, bus_val;

  assign bus_val = bus_pack(bus_addr_hi, bus_tip, bus_tmode, bus_ttype);

  pmx_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pins_sync)
  );

  pmx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
    .wdata(reg_wdata), .pins_sync(pins_sync), .rdata(reg_rdata),
    .sel_q(sel_q), .dir_q(dir_q), .dat_q(dat_q)
  );

  pmx_pinmux #(.W(PINS), .DRIVES(BUS_DRIVES)) u_mux (
    .sel(sel_q), .dir(dir_q), .dat(dat_q), .bus_val(bus_val),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign dma_req = pins_sync[DREQ_LO+1:DREQ_LO] & sel_q[DREQ_LO+1:DREQ_LO];

  // R8
  dreq_gpio_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req & ~sel_q[DREQ_LO+1:DREQ_LO]) == 2'b00);

  // R8
  dreq_pad_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[DREQ_LO+1:DREQ_LO] & pad_oe[DREQ_LO+1:DREQ_LO]) == 2'b00);

  // R2
  bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_q & BUS_DRIVES) & ~(pad_oe & ~(pad_out ^ bus_val))) == '0);

  // R4
  gpio_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~sel_q) & (pad_out ^ dat_q)) == '0);
endmodule

// File: tb/sim_pmx_port_top.sv
`timescale 1ns/1ps
module sim_pmx_port_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe;
  logic [7:0]  bus_addr_hi = '0;
  logic        bus_tip = 1'b0;
  logic [2:0]  bus_tmode = '0;
  logic [1:0]  bus_ttype = '0;
  logic [1:0]  dma_req;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] m_sel, m_dir, m_dat;

  always #5 clk = ~clk;

  pmx_port_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .bus_addr_hi(bus_addr_hi),
    .bus_tip(bus_tip), .bus_tmode(bus_tmode), .bus_ttype(bus_ttype),
    .dma_req(dma_req)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 12'h004) m_sel = d;
    if (a == 12'h244) m_dir = d;
    if (a == 12'h248) m_dat = d;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [15:0] exp_bus();
    logic [15:0] v = '0;
    for (int i = 0; i < 16; i++) begin
      if (i >= 8)      v[i] = bus_addr_hi[i-8];
      else if (i == 7) v[i] = bus_tip;
      else if (i >= 5) v[i] = 1'b0;
      else if (i >= 2) v[i] = bus_tmode[i-2];
      else             v[i] = bus_ttype[i];
    end
    return v;
  endfunction

  function automatic logic [15:0] exp_oe();
    logic [15:0] v;
    for (int i = 0; i < 16; i++)
      v[i] = m_sel[i] ? !(i == 5 || i == 6) : m_dir[i];
    return v;
  endfunction

  function automatic logic [15:0] exp_out();
    logic [15:0] b = exp_bus();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) v[i] = m_sel[i] ? b[i] : m_dat[i];
    return v;
  endfunction

  task automatic chk_pads(input string tag);
    #1;
    chk({tag, " oe"}, pad_oe, exp_oe());
    chk({tag, " out"}, pad_out, exp_out());
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    m_sel = 16'hFFFF; m_dir = '0; m_dat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h004, r); chk("R1 sel reset", r, 16'hFFFF);
    rd(12'h244, r); chk("R1 dir reset", r, 16'h0000);
    rd(12'h248, r); chk("R1 dat reset", r, 16'h0000);
    chk_pads("R1 pads");

    // R9 undefined offsets read zero
    rd(12'h000, r); chk("R9 undef 000", r, 16'h0);
    rd(12'h240, r); chk("R9 undef 240", r, 16'h0);
    rd(12'h24C, r); chk("R9 undef 24C", r, 16'h0);
    rd(12'hFFF, r); chk("R9 undef FFF", r, 16'h0);

    // R2 bus-function sweep
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      bus_addr_hi = 8'(k * 37 + 5);
      bus_tip     = k[0];
      bus_tmode   = 3'(k >> 1);
      bus_ttype   = 2'(k >> 3);
      chk_pads("R2 bus sweep");
    end

    // R7 gpio registers inert on bus-owned pads
    wr(12'h244, 16'hFFFF);
    wr(12'h248, 16'h5A5A);
    chk_pads("R7 after writes");
    wr(12'h244, 16'h0000);
    chk_pads("R7 dir cleared");

    // R9 writes to undefined offsets change nothing
    wr(12'h100, 16'h1234);
    wr(12'h246, 16'hABCD);
    rd(12'h004, r); chk("R9 sel intact", r, 16'hFFFF);
    rd(12'h244, r); chk("R9 dir intact", r, 16'h0000);

    // R3 R4 per-pin GPIO sweep
    wr(12'h004, 16'h0000);
    for (int i = 0; i < 16; i++) begin
      wr(12'h244, 16'(1 << i));
      wr(12'h248, 16'(~(1 << i)) ^ 16'h5A5A);
      chk_pads("R3 R4 single pin");
      wr(12'h244, ~16'(1 << i));
      chk_pads("R3 R4 inverse");
    end

    // R5 read-back with two-edge latency
    wr(12'h244, 16'h00FF);
    wr(12'h248, 16'hA5A5);
    pad_in = 16'h3C96;
    @(negedge clk);
    rd(12'h248, r); chk("R5 one edge", r, 16'h00A5);
    @(negedge clk);
    rd(12'h248, r); chk("R5 two edges", r, 16'h3CA5);
    wr(12'h248, 16'hFFFF);
    rd(12'h248, r); chk("R5 input bits unaffected", r, 16'h3CFF);
    pad_in = 16'hC369;
    repeat (2) @(negedge clk);
    rd(12'h248, r); chk("R5 new pattern", r, 16'hC3FF);

    // R6 latched data drives on direction change
    wr(12'h244, 16'h0000);
    wr(12'h248, 16'h3C3C);
    chk_pads("R6 inputs");
    chk("R6 no drive", pad_oe, 16'h0000);
    wr(12'h244, 16'hFFFF);
    chk("R6 drives latched", pad_out, 16'h3C3C);
    chk("R6 oe", pad_oe, 16'hFFFF);

    // R8 DMA request pads
    wr(12'h004, 16'hFFFF);
    for (int p = 0; p < 4; p++) begin
      pad_in = 16'(p << 5);
      repeat (2) @(negedge clk);
      #1;
      chk("R8 dreq follows", {14'd0, dma_req}, 16'(p));
      chk("R8 pads released", pad_oe & 16'h0060, 16'h0000);
    end
    wr(12'h004, 16'hFF9F);
    #1 chk("R8 gpio dreq low", {14'd0, dma_req}, 16'h0);

    // R2 R4 mixed ownership
    wr(12'h004, 16'hF0F0);
    wr(12'h244, 16'h0F0F);
    wr(12'h248, 16'h6666);
    chk_pads("R2 R4 mixed");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule